// File: doc/BRIEF.md
# Byte-Lane Selected Static Memory Core

A word-organised static memory whose data word is split into three 8-bit lanes. Each lane has its own active-low select, so a host can read or write any subset of the three bytes at one address without a read-modify-write. Shared active-low write-enable and output-enable choose between writing, reading with the bus driven, and holding the bus undriven. The block reports power-down whenever no lane is selected.

The bidirectional data bus is split into a write-data input, a read-data output and a per-lane drive-enable output. A pad ring or an on-chip bus multiplexer can build a tri-state pin from these three signals. Writes take effect on the rising clock edge. Read data is combinational from the address by default. A parameter can place one register stage behind the read path. Storage is not reset. Reset clears only the optional read register.

Top module: `lanemem_core`

## Requirements
- R1: Lane mapping is fixed: `sel_n[0]` owns data bits 7:0, `sel_n[1]` owns bits 15:8 and `sel_n[2]` owns bits 23:16, for both reads and writes.
- R2: On a rising clock edge with `we_n` low, every lane whose select is low stores its slice of `wdata` at `addr`. Every lane whose select is high keeps its stored slice.
- R3: While `we_n` is low, the cycle is a write whatever `oe_n` is. The write lands identically with `oe_n` high or low, and all bits of `drive_en` are 0.
- R4: With the default combinational read, `drive_en[i]` is 1 exactly when `sel_n[i]` is low, `we_n` is high and `oe_n` is low. While a lane is driven, its slice of `rdata` equals the stored slice. While it is not driven, that slice reads 0.
- R5: When all three selects are high, or when `oe_n` is high during a read, `drive_en` is 0 and `rdata` is all zeros.
- R6: `pdown` is 1 exactly when all three selects are high. An access, meaning any select low, made before `pwr_ready` has ever been high since reset is a protocol error.
- R7: With all three selects low, a write stores the full 24-bit word and a read returns the full 24-bit word.
- R8: With the default combinational read, `rdata` follows a change of `addr` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on rising edge |
| rst | input | 1 | Synchronous active-high reset (read register only) |
| pwr_ready | input | 1 | High once the memory may be accessed |
| addr | input | ADDR_W | Word address |
| sel_n | input | 3 | Active-low lane selects |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| wdata | input | 24 | Write data, three lanes |
| rdata | output | 24 | Read data, zero in undriven lanes |
| drive_en | output | 3 | Per-lane output-drive enable |
| pdown | output | 1 | High when no lane is selected |

## Verification
The bench sweeps all eight select patterns against all four write-enable and output-enable combinations on two addresses. After each write, it reads the whole word back. A design with swapped lane slices would return bytes in the wrong positions. A design that writes unselected lanes would corrupt the neighbouring bytes in the read-back. A design that lets output-enable gate writes, or that drives the bus during a write, would miss stores or show nonzero `drive_en`. Back-to-back reads on changing addresses expose a read path that lags by a cycle. Idle and output-disabled cycles expose leakage of stale data onto `rdata` and a wrong `pdown`.

// File: rtl/lanemem_pkg.sv
package lanemem_pkg;

    localparam int NLANES = 3;

    typedef enum logic [1:0] {
        OP_STANDBY = 2'd0,
        OP_READ    = 2'd1,
        OP_WRITE   = 2'd2,
        OP_NODRIVE = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [NLANES-1:0] wr_lane;
        logic [NLANES-1:0] rd_lane;
        logic              pdown;
    } ctrl_t;

    // Mode from "no lane selected", write strobe and output enable.
    function automatic op_e decode_op(input logic none_sel,
                                      input logic we_n,
                                      input logic oe_n);
        if (none_sel)   return OP_STANDBY;
        else if (!we_n) return OP_WRITE;
        else if (!oe_n) return OP_READ;
        else            return OP_NODRIVE;
    endfunction

endpackage

// File: rtl/lanemem_ctrl.sv
module lanemem_ctrl
    import lanemem_pkg::*;
(
    input  logic [NLANES-1:0] sel_n,
    input  logic              we_n,
    input  logic              oe_n,
    output ctrl_t             ctrl
);
    op_e op;

    always_comb begin
        op           = decode_op(&sel_n, we_n, oe_n);
        ctrl.op      = op;
        ctrl.pdown   = (op == OP_STANDBY);
        ctrl.wr_lane = (op == OP_WRITE) ? ~sel_n : '0;
        ctrl.rd_lane = (op == OP_READ)  ? ~sel_n : '0;
    end
endmodule

// File: rtl/lanemem_array.sv
module lanemem_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8,
    parameter int LANES  = 3
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lane[l])
                store[addr] <= wdata[l*LANE_W +: LANE_W];
        end

        assign rd_word[l*LANE_W +: LANE_W] = store[addr];
    end
endmodule

// File: rtl/lanemem_rdpath.sv
module lanemem_rdpath #(
    parameter int LANE_W   = 8,
    parameter int LANES    = 3,
    parameter bit READ_REG = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        rd_lane,
    input  logic [LANES*LANE_W-1:0] rd_word,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        drive_en
);
    logic [LANES*LANE_W-1:0] masked;

    for (genvar l = 0; l < LANES; l++) begin : g_mask
        assign masked[l*LANE_W +: LANE_W] =
            rd_lane[l] ? rd_word[l*LANE_W +: LANE_W] : '0;
    end

    if (READ_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata    <= '0;
                drive_en <= '0;
            end else begin
                rdata    <= masked;
                drive_en <= rd_lane;
            end
        end
    end else begin : g_comb
        assign rdata    = masked;
        assign drive_en = rd_lane;
    end
endmodule

// File: rtl/lanemem_core.sv
module lanemem_core
    import lanemem_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int LANE_W   = 8,
    parameter bit READ_REG = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pwr_ready,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NLANES-1:0]        sel_n,
    input  logic                     we_n,
    input  logic                     oe_n,
    input  logic [NLANES*LANE_W-1:0] wdata,
    output logic [NLANES*LANE_W-1:0] rdata,
    output logic [NLANES-1:0]        drive_en,
    output logic                     pdown
);
    localparam int WORD_W = NLANES * LANE_W;

    ctrl_t             ctrl;
    logic [WORD_W-1:0] rd_word;

    lanemem_ctrl u_ctrl (
        .sel_n (sel_n),
        .we_n  (we_n),
        .oe_n  (oe_n),
        .ctrl  (ctrl)
    );

    lanemem_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(NLANES)) u_array (
        .clk     (clk),
        .addr    (addr),
        .wr_lane (ctrl.wr_lane),
        .wdata   (wdata),
        .rd_word (rd_word)
    );

    lanemem_rdpath #(.LANE_W(LANE_W), .LANES(NLANES), .READ_REG(READ_REG)) u_rdpath (
        .clk      (clk),
        .rst      (rst),
        .rd_lane  (ctrl.rd_lane),
        .rd_word  (rd_word),
        .rdata    (rdata),
        .drive_en (drive_en)
    );

    assign pdown = ctrl.pdown;
endmodule

// File: rtl/lanemem_chk.sv
module lanemem_chk #(
    parameter int ADDR_W   = 6,
    parameter int LANE_W   = 8,
    parameter int LANES    = 3,
    parameter bit READ_REG = 1'b0
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    pwr_ready,
    input logic [ADDR_W-1:0]       addr,
    input logic [LANES-1:0]        sel_n,
    input logic                    we_n,
    input logic                    oe_n,
    input logic [LANES*LANE_W-1:0] wdata,
    input logic [LANES*LANE_W-1:0] rdata,
    input logic [LANES-1:0]        drive_en,
    input logic                    pdown
);
    localparam bit COMB = (READ_REG == 1'b0);

    logic ready_seen;
    always_ff @(posedge clk) begin
        if (rst) ready_seen <= 1'b0;
        else if (pwr_ready) ready_seen <= 1'b1;
    end

    // R3: no lane driven while writing
    p_no_drive_on_write_r3: assert property (@(posedge clk) disable iff (rst)
        (COMB && !we_n) |-> (drive_en == '0));

    // R5: idle or output-disabled read leaves bus undriven and zero
    p_quiet_bus_r5: assert property (@(posedge clk) disable iff (rst)
        (COMB && ((&sel_n) || (we_n && oe_n))) |-> (drive_en == '0 && rdata == '0));

    // R6: power-down flag tracks the all-deselected state
    p_pdown_r6: assert property (@(posedge clk) disable iff (rst)
        pdown == (&sel_n));

    // R6: no access before power-up-ready has been seen
    p_early_access_r6: assert property (@(posedge clk) disable iff (rst)
        !(ready_seen || pwr_ready) |-> (&sel_n));

    // R2: a lane written last cycle reads back its data at the same address
    for (genvar l = 0; l < LANES; l++) begin : g_wr
        p_lane_readback_r2: assert property (@(posedge clk) disable iff (rst)
            (COMB && $past(!sel_n[l] && !we_n) && addr == $past(addr)
             && !sel_n[l] && we_n && !oe_n)
            |-> rdata[l*LANE_W +: LANE_W] == $past(wdata[l*LANE_W +: LANE_W]));
    end
endmodule

bind lanemem_core lanemem_chk #(
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(lanemem_pkg::NLANES), .READ_REG(READ_REG)
) u_chk (
    .clk(clk), .rst(rst), .pwr_ready(pwr_ready), .addr(addr), .sel_n(sel_n),
    .we_n(we_n), .oe_n(oe_n), .wdata(wdata), .rdata(rdata),
    .drive_en(drive_en), .pdown(pdown)
);

// File: tb/lanemem_core_bench.sv
module lanemem_core_bench;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        logic [23:0] rdata;
        logic [2:0]  drive;
        logic        pdown;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_ready = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [2:0]    sel_n = 3'b111;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [23:0]   wdata = '0;
    logic [23:0]   rdata;
    logic [2:0]    drive_en;
    logic          pdown;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t        sb[$];
    logic [23:0] model [DEPTH];

    always #2 clk = ~clk;

    lanemem_core #(.ADDR_W(AW)) u_lanemem_core (
        .clk(clk), .rst(rst), .pwr_ready(pwr_ready), .addr(addr), .sel_n(sel_n),
        .we_n(we_n), .oe_n(oe_n), .wdata(wdata), .rdata(rdata),
        .drive_en(drive_en), .pdown(pdown)
    );

    function automatic logic [23:0] pat(input int a, input int k);
        return {8'(a * 7 + k), 8'(~a + k * 3), 8'(a ^ 8'h5A ^ k)};
    endfunction

    // Driver: apply one cycle, push the expected outputs for that cycle.
    task automatic step(input logic [AW-1:0] a, input logic [2:0] s,
                        input logic w, input logic o, input logic [23:0] d,
                        input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        addr = a; sel_n = s; we_n = w; oe_n = o; wdata = d;
        for (int l = 0; l < 3; l++) begin
            e.drive[l] = !s[l] && w && !o;
            e.rdata[l*8 +: 8] = e.drive[l] ? model[a][l*8 +: 8] : 8'h00;
        end
        e.pdown = &s;
        e.tag   = tag;
        sb.push_back(e);
        if (!w)
            for (int l = 0; l < 3; l++)
                if (!s[l]) model[a][l*8 +: 8] = d[l*8 +: 8];
    endtask

    // Monitor: compare in the same cycle, away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (rdata !== e.rdata || drive_en !== e.drive || pdown !== e.pdown) begin
                    fails++;
                    $display("FAIL %s: rdata=%h drive_en=%b pdown=%b expected rdata=%h drive_en=%b pdown=%b",
                             e.tag, rdata, drive_en, pdown, e.rdata, e.drive, e.pdown);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        pwr_ready = 1'b1;
        // R6/R5: idle after reset is powered down with bus quiet
        step('0, 3'b111, 1'b1, 1'b0, '0, "R6 reset idle");

        // R7/R3: full-word fill, output-enable alternating during writes
        for (int a = 0; a < DEPTH; a++)
            step(AW'(a), 3'b000, 1'b0, a[0], pat(a, 0), "R3 R7 full write");
        // R7/R1: full-word read back
        for (int a = 0; a < DEPTH; a++)
            step(AW'(a), 3'b000, 1'b1, 1'b0, '0, "R7 R1 full read");

        // Truth-table sweep, each followed by a full read to expose lane damage (R2)
        for (int ai = 0; ai < 2; ai++) begin
            logic [AW-1:0] a;
            a = (ai == 0) ? AW'(3) : AW'(40);
            for (int s = 0; s < 8; s++)
                for (int w = 0; w < 2; w++)
                    for (int o = 0; o < 2; o++) begin
                        string t;
                        if (w == 0)      t = "R3 write ignores oe";
                        else if (s == 7) t = "R6 R5 standby";
                        else if (o == 1) t = "R5 outputs disabled";
                        else             t = "R4 R1 lane read";
                        step(a, 3'(s), 1'(w), 1'(o), pat(s * 4 + w * 2 + o, 9), t);
                        step(a, 3'b000, 1'b1, 1'b0, '0, "R2 lane keep");
                    end
        end

        // R8: address changes every cycle, data follows immediately
        for (int a = DEPTH - 1; a >= 0; a -= 5)
            step(AW'(a), 3'b000, 1'b1, 1'b0, '0, "R8 same-cycle read");
        step('0, 3'b111, 1'b1, 1'b1, '0, "R6 final idle");

        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule